// File: doc/BRIEF.md
# Closed-Row DRAM Cache-Line Read Sequencer

This block fetches one 64-byte cache line from DRAM over a 64-bit data interface, running on a 10 ns clock. Every line read is treated as a row miss. After a request is taken, the block spends one cycle setting up. It then issues a precharge, waits the precharge time and opens the row with an activate. After the activate delay it issues eight column reads on consecutive cycles, one for each 8-byte double word. Refresh is not handled.

The DRAM returns each double word a fixed CAS latency after its column read. The block captures it and places it on the processor-side bus one cycle later, together with a valid strobe and the beat number. A busy flag stays high from the cycle after a request is taken until the last beat has been delivered. While busy is high, new requests are ignored. The precharge time (TRP), the activate-to-read delay (TRCD) and the CAS latency (CL) are parameters, each at least 1 and each 2 by default.

Top module: `line_read_ctrl`

## Requirements
- R1: After reset, and before any request is taken, `busy` and `fwd_valid` are 0 and `dram_cmd` is NOP (code 0).
- R2: A request is taken on a rising edge where `req_valid` is 1 and `busy` is 0. The cycle after that edge is a setup cycle that carries NOP, and the cycle after that carries PRECHARGE (code 1).
- R3: ACTIVATE (code 2) comes exactly TRP cycles after PRECHARGE. `dram_row` then carries the row field, which is the upper ROW_W bits of `req_line` as they were on the accept edge.
- R4: The first READ (code 3) comes exactly TRCD cycles after ACTIVATE. Eight READs follow on consecutive cycles. Beat i carries `dram_col` = {line column field (the low bits of `req_line`), i[2:0]}.
- R5: Apart from the commands listed in R2, R3 and R4, `dram_cmd` is NOP in every cycle.
- R6: The value on `dram_dq` exactly CL cycles after the READ for beat i appears on `fwd_data` one cycle later. In that cycle `fwd_valid` is 1 and `fwd_beat` is i. Beats come out in order 0 to 7 on consecutive cycles, and `fwd_valid` is 0 in every other cycle.
- R7: The last beat appears 10 + TRP + TRCD + CL cycles after the accept edge. This is 1 setup cycle, plus TRP, plus TRCD, plus CL, plus 8 beats, plus 1 forwarding cycle.
- R8: `busy` is 1 from the cycle after the accept edge through the cycle of the last beat, and 0 otherwise. A request made while `busy` is 1 has no effect on any output.
- R9: If `req_valid` is held high, the next request is taken in the first cycle in which `busy` is 0. This gives back-to-back line reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Line read request |
| req_line | input | ROW_W+COL_W-3 | {row, line column} of the requested line |
| busy | output | 1 | High while a line read is in progress |
| dram_cmd | output | 2 | 0 NOP, 1 PRECHARGE, 2 ACTIVATE, 3 READ |
| dram_row | output | ROW_W | Row address, valid with ACTIVATE |
| dram_col | output | COL_W | Column address in double words, valid with READ |
| dram_dq | input | DATA_W | Read data from the DRAM |
| fwd_valid | output | 1 | Forwarded double word valid |
| fwd_beat | output | 3 | Index of the forwarded double word |
| fwd_data | output | DATA_W | Forwarded double word |

## Verification
The bench builds the block with TRP=3, TRCD=1 and CL=2. All three values are different, so if one delay is used in place of another, the command cycles move and the checks catch it. TRCD=1 drives the sequencer through its path that has no wait state. The full latency is 16 cycles, which differs from the 16-cycle default only in how it is made up, so each stage is checked one cycle at a time. A DRAM model in the bench returns data that depends on the address only in the exact CL slot, and returns junk in every other slot. This makes any error in the capture timing show up.

// File: rtl/lrc_pkg.sv
// Package: shared types for the line read sequencer.
// Assumes: command codes are decoded by the DRAM model or PHY as listed.
package lrc_pkg;
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_ACT = 2'd2,
        CMD_RD  = 2'd3
    } dram_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INIT,
        S_PRE,
        S_WRP,
        S_ACT,
        S_WRCD,
        S_CAS
    } seq_state_e;
endpackage

// File: rtl/lrc_seq.sv
// lrc_seq: command sequencer. For each started line it runs:
// setup, precharge, wait for the precharge time, activate,
// wait for the activate delay, then BEATS column reads.
// Assumes: TRP >= 1, TRCD >= 1, BEATS is a power of two, and start
// only arrives while the sequencer is idle.
module lrc_seq
    import lrc_pkg::*;
#(
    parameter int TRP    = 2,
    parameter int TRCD   = 2,
    parameter int BEATS  = 8,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [ROW_W+COL_W-$clog2(BEATS)-1:0] line_addr,
    output dram_cmd_e                cmd,
    output logic [ROW_W-1:0]         row,
    output logic [COL_W-1:0]         col,
    output logic                     cas_fire,
    output logic [$clog2(BEATS)-1:0] cas_beat
);
    localparam int BEAT_W  = $clog2(BEATS);
    localparam int LC_W    = COL_W - BEAT_W;
    localparam int GAP_MAX = (TRP > TRCD) ? TRP : TRCD;
    localparam int CNT_W   = $clog2(GAP_MAX + 1);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    seq_state_e        state_q;
    logic [CNT_W-1:0]  gap_q;
    logic [BEAT_W-1:0] beat_q;
    logic [ROW_W-1:0]  row_q;
    logic [LC_W-1:0]   lc_q;

    // Purpose: state, wait counter, beat counter and address latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            gap_q   <= '0;
            beat_q  <= '0;
            row_q   <= '0;
            lc_q    <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_INIT;
                    row_q   <= line_addr[LC_W +: ROW_W];
                    lc_q    <= line_addr[LC_W-1:0];
                end
                S_INIT: state_q <= S_PRE;
                S_PRE: begin
                    if (TRP > 1) begin
                        state_q <= S_WRP;
                        gap_q   <= CNT_W'(TRP - 2);
                    end else begin
                        state_q <= S_ACT;
                    end
                end
                S_WRP: begin
                    if (gap_q == '0) state_q <= S_ACT;
                    else             gap_q   <= gap_q - 1'b1;
                end
                S_ACT: begin
                    beat_q <= '0;
                    if (TRCD > 1) begin
                        state_q <= S_WRCD;
                        gap_q   <= CNT_W'(TRCD - 2);
                    end else begin
                        state_q <= S_CAS;
                    end
                end
                S_WRCD: begin
                    if (gap_q == '0) state_q <= S_CAS;
                    else             gap_q   <= gap_q - 1'b1;
                end
                S_CAS: begin
                    if (beat_q == LAST_BEAT) state_q <= S_IDLE;
                    else                     beat_q  <= beat_q + 1'b1;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Purpose: decode the current state into a DRAM command.
    always_comb begin
        case (state_q)
            S_PRE:   cmd = CMD_PRE;
            S_ACT:   cmd = CMD_ACT;
            S_CAS:   cmd = CMD_RD;
            default: cmd = CMD_NOP;
        endcase
    end

    assign row      = row_q;
    assign col      = {lc_q, beat_q};
    assign cas_fire = (state_q == S_CAS);
    assign cas_beat = beat_q;
endmodule

// File: rtl/lrc_capture.sv
// lrc_capture: carries a tag for each read through a CL-deep pipe.
// When a tag reaches the end of the pipe, the data on the DRAM bus is
// captured and forwarded with its beat index one cycle later.
// Assumes: CL >= 1, and the DRAM drives its data exactly CL cycles after each read.
module lrc_capture #(
    parameter int CL     = 2,
    parameter int BEATS  = 8,
    parameter int DATA_W = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cas_fire,
    input  logic [$clog2(BEATS)-1:0] cas_beat,
    input  logic [DATA_W-1:0]        dram_dq,
    output logic                     fwd_valid,
    output logic [$clog2(BEATS)-1:0] fwd_beat,
    output logic [DATA_W-1:0]        fwd_data
);
    localparam int BEAT_W = $clog2(BEATS);

    logic              tag_v [CL];
    logic [BEAT_W-1:0] tag_b [CL];

    // Purpose: first pipe stage, loaded from the read issued this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_v[0] <= 1'b0;
            tag_b[0] <= '0;
        end else begin
            tag_v[0] <= cas_fire;
            tag_b[0] <= cas_beat;
        end
    end

    for (genvar i = 1; i < CL; i++) begin : g_stage
        // Purpose: move the tag one stage closer to the data slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_v[i] <= 1'b0;
                tag_b[i] <= '0;
            end else begin
                tag_v[i] <= tag_v[i-1];
                tag_b[i] <= tag_b[i-1];
            end
        end
    end

    // Purpose: capture the DRAM data in its slot and forward it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_beat  <= '0;
            fwd_data  <= '0;
        end else begin
            fwd_valid <= tag_v[CL-1];
            fwd_beat  <= tag_b[CL-1];
            if (tag_v[CL-1]) fwd_data <= dram_dq;
        end
    end
endmodule

// File: rtl/line_read_ctrl.sv
// line_read_ctrl: top level of the closed-row cache-line read path.
// It takes a request when idle and keeps busy high until the last
// double word has been forwarded.
// Assumes: a single bank, no refresh, and read requests only.
module line_read_ctrl
    import lrc_pkg::*;
#(
    parameter int TRP    = 2,
    parameter int TRCD   = 2,
    parameter int CL     = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int DATA_W = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [ROW_W+COL_W-4:0] req_line,
    output logic                   busy,
    output logic [1:0]             dram_cmd,
    output logic [ROW_W-1:0]       dram_row,
    output logic [COL_W-1:0]       dram_col,
    input  logic [DATA_W-1:0]      dram_dq,
    output logic                   fwd_valid,
    output logic [2:0]             fwd_beat,
    output logic [DATA_W-1:0]      fwd_data
);
    localparam int BEATS = 8;

    dram_cmd_e  cmd_w;
    logic       cas_fire_w;
    logic [2:0] cas_beat_w;
    logic       busy_q;
    logic       accept;

    assign accept = req_valid && !busy_q;

    // Purpose: busy flag, set on accept and cleared after the last beat.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  busy_q <= 1'b0;
        else if (accept)                             busy_q <= 1'b1;
        else if (fwd_valid && fwd_beat == 3'(BEATS-1)) busy_q <= 1'b0;
    end

    lrc_seq #(
        .TRP(TRP), .TRCD(TRCD), .BEATS(BEATS), .ROW_W(ROW_W), .COL_W(COL_W)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .start(accept), .line_addr(req_line),
        .cmd(cmd_w), .row(dram_row), .col(dram_col),
        .cas_fire(cas_fire_w), .cas_beat(cas_beat_w)
    );

    lrc_capture #(
        .CL(CL), .BEATS(BEATS), .DATA_W(DATA_W)
    ) cap_i (
        .clk(clk), .rst_n(rst_n), .cas_fire(cas_fire_w), .cas_beat(cas_beat_w),
        .dram_dq(dram_dq), .fwd_valid(fwd_valid), .fwd_beat(fwd_beat),
        .fwd_data(fwd_data)
    );

    assign busy     = busy_q;
    assign dram_cmd = cmd_w;
endmodule

// File: rtl/lrc_checker.sv
// lrc_checker: protocol properties for line_read_ctrl, attached by bind.
// Assumes: command codes 0 NOP, 1 PRECHARGE, 2 ACTIVATE, 3 READ.
module lrc_checker #(
    parameter int TRP   = 2,
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [1:0]       dram_cmd,
    input logic [COL_W-1:0] dram_col,
    input logic             fwd_valid,
    input logic [2:0]       fwd_beat
);
    logic [15:0] since_pre;

    // Purpose: count cycles since the last precharge, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_pre <= '0;
        else if (dram_cmd == 2'd1) since_pre <= 16'd1;
        else if (since_pre != '0 && since_pre != 16'hFFFF) since_pre <= since_pre + 16'd1;
    end

    p_setup_nop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> dram_cmd == 2'd0);

    p_act_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dram_cmd == 2'd2 |-> since_pre == 16'(TRP));

    p_col_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cmd == 2'd3 && $past(dram_cmd) == 2'd3) |-> dram_col == $past(dram_col) + 1'b1);

    p_cmd_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dram_cmd != 2'd0 |-> busy);

    p_beat_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_beat != 3'd0) |-> ($past(fwd_valid) && fwd_beat == $past(fwd_beat) + 3'd1));

    p_fwd_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> busy);

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_beat == 3'd7) |=> !busy);
endmodule

bind line_read_ctrl lrc_checker #(.TRP(TRP), .COL_W(COL_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .dram_cmd(dram_cmd),
    .dram_col(dram_col), .fwd_valid(fwd_valid), .fwd_beat(fwd_beat)
);

// File: tb/line_read_ctrl_tb_top.sv
// Bench: a behavioural reference, built from the accept times, is compared
// against the ports once per cycle. A DRAM model answers the READ commands.
module line_read_ctrl_tb_top;
    localparam int TRP = 3, TRCD = 1, CL = 2;
    localparam int ROW_W = 13, COL_W = 10, DATA_W = 64;
    localparam int LC_W = COL_W - 3;
    localparam int SUM = TRP + TRCD + CL;
    localparam int LAT = 10 + SUM;
    localparam logic [63:0] JUNK = 64'hBAD0_BAD0_BAD0_BAD0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [LC_W-1:0]  req_lc = '0;
    logic busy, fwd_valid;
    logic [1:0] dram_cmd;
    logic [ROW_W-1:0] dram_row;
    logic [COL_W-1:0] dram_col;
    logic [DATA_W-1:0] dram_dq = JUNK;
    logic [2:0] fwd_beat;
    logic [DATA_W-1:0] fwd_data;

    int errors = 0, checks = 0, cyc = 0;
    int busy_from = -1, busy_until = -1, last_acc = -1, accepts = 0, b2b = 0;
    bit any_acc = 0;
    int e_cmd [int];
    int e_row [int];
    int e_col [int];
    int e_beat [int];
    logic [63:0] e_dat [int];
    logic [63:0] sched [int];
    int act_row = 0;

    always #5 clk = ~clk;

    line_read_ctrl #(.TRP(TRP), .TRCD(TRCD), .CL(CL), .ROW_W(ROW_W),
                     .COL_W(COL_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line({req_row, req_lc}),
        .busy(busy), .dram_cmd(dram_cmd), .dram_row(dram_row), .dram_col(dram_col),
        .dram_dq(dram_dq), .fwd_valid(fwd_valid), .fwd_beat(fwd_beat), .fwd_data(fwd_data)
    );

    function automatic logic [63:0] pat(int row, int col);
        return {32'(row) * 32'h9E37_79B9, 32'(col) ^ 32'h5A5A_0000};
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // DRAM model: drives the read data CL cycles after each READ.
    always @(posedge clk) begin
        #1;
        dram_dq = sched.exists(cyc) ? sched[cyc] : JUNK;
    end

    // Reference model and per-cycle comparison.
    always @(negedge clk) begin
        if (rst_n) begin
            int c, ecmd;
            bit ebusy, ev;
            string tag;
            c = cyc;
            if (req_valid && c > busy_until) begin
                if (any_acc && c == busy_until + 1) b2b++;
                any_acc = 1;
                accepts++;
                last_acc = c;
                busy_from = c + 1;
                busy_until = c + LAT;
                e_cmd[c+2] = 1;
                e_cmd[c+2+TRP] = 2;
                e_row[c+2+TRP] = int'(req_row);
                for (int i = 0; i < 8; i++) begin
                    e_cmd[c+2+TRP+TRCD+i] = 3;
                    e_col[c+2+TRP+TRCD+i] = int'({req_lc, 3'(i)});
                    e_beat[c+3+SUM+i] = i;
                    e_dat[c+3+SUM+i] = pat(int'(req_row), int'({req_lc, 3'(i)}));
                end
            end
            ecmd = e_cmd.exists(c) ? e_cmd[c] : 0;
            case (ecmd)
                1: tag = "R2";
                2: tag = "R3";
                3: tag = "R4";
                default: tag = any_acc ? "R5 R8" : "R1";
            endcase
            chk(dram_cmd == 2'(ecmd), tag, "dram_cmd", dram_cmd, ecmd);
            if (ecmd == 2) chk(dram_row == ROW_W'(e_row[c]), "R3", "dram_row", dram_row, e_row[c]);
            if (ecmd == 3) chk(dram_col == COL_W'(e_col[c]), "R4", "dram_col", dram_col, e_col[c]);
            ebusy = (c >= busy_from && c <= busy_until);
            chk(busy == ebusy, any_acc ? "R8" : "R1", "busy", busy, ebusy);
            ev = e_dat.exists(c);
            chk(fwd_valid == ev, any_acc ? "R6" : "R1", "fwd_valid", fwd_valid, ev);
            if (ev && fwd_valid) begin
                chk(fwd_beat == 3'(e_beat[c]), "R6", "fwd_beat", fwd_beat, e_beat[c]);
                chk(fwd_data == e_dat[c], "R6", "fwd_data", fwd_data, e_dat[c]);
                if (fwd_beat == 3'd7)
                    chk(c - last_acc == LAT, "R7", "latency", c - last_acc, LAT);
            end
            if (dram_cmd == 2'd2) act_row = int'(dram_row);
            if (dram_cmd == 2'd3) sched[c+CL] = pat(act_row, int'(dram_col));
        end
    end

    task automatic pulse(int row, int lc);
        @(posedge clk); #1;
        req_row = ROW_W'(row); req_lc = LC_W'(lc); req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        idle(5); #1;
        rst_n = 1'b1;
        idle(3); #1;
        chk(busy == 1'b0 && fwd_valid == 1'b0 && dram_cmd == 2'd0, "R1", "idle after reset",
            {busy, fwd_valid, dram_cmd}, 0);
        pulse(5, 3);
        idle(LAT + 4);
        pulse((1 << ROW_W) - 1, (1 << LC_W) - 1);
        idle(4);
        pulse(77, 9);               // R8: made while busy, must be ignored
        idle(LAT + 6);
        @(posedge clk); #1;
        req_row = 13'd100; req_lc = 7'd7; req_valid = 1'b1;   // R9: held request
        idle(2 * LAT + 4); #1;
        req_valid = 1'b0;
        idle(LAT + 4);
        for (int k = 0; k < 3; k++) begin
            pulse(1000 + k * 311, 17 * k + 1);
            idle(LAT + 2 + k);
        end
        idle(10); #1;
        chk(b2b >= 1, "R9", "back-to-back accepts", b2b, 1);
        chk(accepts == 8, "R8", "accept count", accepts, 8);
        finish_run();
    end

    initial begin
        idle(20000);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end
endmodule